// File: doc/BRIEF.md
# I2C SCL Rate Generator with Asymmetric Duty

This block paces the SCL clock of an I2C master from a fast source clock. It outputs the SCL level that the master should drive, where 1 means released high and 0 means pulled low. It also outputs two one-cycle strobes that mark each falling and each rising SCL edge, so that the bus bit engine can shift data on the correct edge. The low and high phases are timed separately. Standard mode uses the same length for both phases. The fast modes use a short high phase and a long low phase, which gives roughly one third high and two thirds low.

Timing comes from a 32-bit divider word. Three fields matter: an 8-bit low-phase divider, an 8-bit high-phase divider, and an 8-bit high-speed divider field that is kept in the word but has no effect on SCL pacing. The word is captured only while the engine is stopped, so a transfer in progress always keeps one timing. During the high phase the block watches a registered sample of the bus SCL line. While a target holds SCL low, the high-phase count waits. This is how clock stretching is supported.

A typical setup with a 19.2 MHz source and a 100 kHz bus uses a low divider of 93 and a high field of 0, which gives 96 + 96 source cycles per bit.

Top module: `scl_rate_gen`

## Requirements
- R1: When `div_word[23:16]` is zero, the low phase and the high phase each last `div_word[7:0]` + 3 source cycles.
- R2: When `div_word[23:16]` is nonzero, the high phase lasts `div_word[23:16]` + 3 cycles and the low phase lasts `div_word[7:0]` + 3 cycles. The full period is the sum of both dividers plus 6.
- R3: `scl_fall` is high for exactly the one cycle in which `scl_out` first reads 0. `scl_rise` is high for exactly the one cycle in which `scl_out` first reads 1. The two strobes are never high together.
- R4: Out of reset, `scl_out` is 1 and both strobes are 0. One cycle after `run` goes low, `scl_out` is 1 and no strobe fires, even if SCL was in its low phase.
- R5: After `run` rises, the engine first times a high phase. The first `scl_fall` appears one high-phase length after the first clock edge that sees `run` high.
- R6: In the high phase, the counter advances only in cycles whose registered sample of `scl_in` is 1. Each held cycle lengthens the high phase by one cycle.
- R7: `div_word` is captured only on edges where `run` is low. Changing it while `run` is high has no effect on the running timing.
- R8: Bits 15:8 and 31:24 of `div_word` have no effect on SCL timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Engine enable; while low the divider word is captured |
| div_word | input | 32 | Divider word: low divider in bits 7:0, high divider in bits 23:16 |
| scl_in | input | 1 | SCL line as seen on the bus, used for stretch detection |
| scl_out | output | 1 | SCL level to drive (1 = released) |
| scl_rise | output | 1 | One-cycle strobe on the first cycle of SCL high |
| scl_fall | output | 1 | One-cycle strobe on the first cycle of SCL low |

## Verification
A wrong phase count shows up directly as a wrong spacing between consecutive strobes, and it is visible on the very next edge after the fault. The bench therefore measures every gap from strobe to strobe against the phase lengths implied by the divider word. A divider word that is captured at the wrong time only shows up when the bench changes the word in the middle of a run: every later gap in that run then has the new length instead of the old one. A fault in stretch handling shifts the falling strobe by the number of held cycles in the first stretched bit. A fault in idle handling leaves `scl_out` low, or emits a stray strobe, in the cycle after `run` drops.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int FIELD_W = 8,
  parameter int PAD_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [4*FIELD_W-1:0] div_word,
  input  logic                 scl_in,
  output logic                 scl_out,
  output logic                 scl_rise,
  output logic                 scl_fall
);
  localparam int LEN_W = FIELD_W + 1;

  logic [FIELD_W-1:0] lo_div, hi_div;
  logic [LEN_W-1:0]   lo_len, hi_len, cnt;
  logic               scl_s;

  wire unused_div_bits = ^{div_word[4*FIELD_W-1:3*FIELD_W], div_word[2*FIELD_W-1:FIELD_W]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_div <= '0;
      hi_div <= '0;
    end else if (!run) begin
      lo_div <= div_word[FIELD_W-1:0];
      hi_div <= div_word[3*FIELD_W-1:2*FIELD_W];
    end

  assign lo_len = LEN_W'(lo_div) + LEN_W'(PAD_CYC);
  assign hi_len = (hi_div == '0) ? lo_len : LEN_W'(hi_div) + LEN_W'(PAD_CYC);

  wire lo_done = (cnt == lo_len - LEN_W'(1));
  wire hi_done = (cnt == hi_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scl_s <= 1'b1;
    else        scl_s <= scl_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_out  <= 1'b1;
      cnt      <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else begin
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      if (!run) begin
        scl_out <= 1'b1;
        cnt     <= '0;
      end else if (scl_out) begin
        if (scl_s) begin
          if (hi_done) begin
            scl_out  <= 1'b0;
            cnt      <= '0;
            scl_fall <= 1'b1;
          end else begin
            cnt <= cnt + LEN_W'(1);
          end
        end
      end else begin
        if (lo_done) begin
          scl_out  <= 1'b1;
          cnt      <= '0;
          scl_rise <= 1'b1;
        end else begin
          cnt <= cnt + LEN_W'(1);
        end
      end
    end
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
  parameter int LEN_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             scl_in,
  input logic             scl_out,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic [LEN_W-1:0] lo_len,
  input logic [LEN_W-1:0] hi_len
);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_fall));

  assert_fall_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> !scl_out);

  assert_rise_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> scl_out);

  assert_fall_marked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $fell(scl_out)) |-> scl_fall);

  assert_idle_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_out && !scl_rise && !scl_fall));

  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && scl_out && !scl_in) ##1 run |=> !scl_fall);

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(lo_len) && $stable(hi_len)));
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.LEN_W(FIELD_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .scl_in(scl_in),
  .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .lo_len(lo_len), .hi_len(hi_len)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] div_word = 32'h0;
  logic        scl_in = 1'b1;
  logic        scl_out, scl_rise, scl_fall;

  int tests = 0;
  int fails = 0;
  int ncyc = 0;
  int stretch_d = -1;
  int hold_cnt = 0;
  bit holding = 1'b0;
  string cur_req = "R1";

  bit exp_kind[$];
  int exp_gap[$];

  always #10 clk = ~clk;

  scl_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_word(div_word),
    .scl_in(scl_in), .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit kind, input int gap);
    exp_kind.push_back(kind);
    exp_gap.push_back(gap);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (run) ncyc++; else ncyc = 0;
      @(negedge clk);
      if (holding) begin
        if (hold_cnt <= 1) begin
          scl_in = 1'b1;
          holding = 1'b0;
        end else hold_cnt--;
      end
      if (scl_rise || scl_fall) begin
        if (exp_kind.size() == 0) begin
          check(1'b0, cur_req, "unexpected strobe (rise)", int'(scl_rise), 0);
        end else begin
          bit k;
          int g;
          k = exp_kind.pop_front();
          g = exp_gap.pop_front();
          check(scl_rise == k && scl_fall == !k, "R3", "strobe kind (1=rise)", int'(scl_rise), int'(k));
          check(ncyc == g, cur_req, k ? "low-phase gap" : "high-phase gap", ncyc, g);
          check(scl_out == k, "R3", "scl_out at strobe", int'(scl_out), int'(k));
        end
        ncyc = 0;
        if (scl_fall && stretch_d >= 0) scl_in = 1'b0;
        if (scl_rise && stretch_d >= 0) begin
          if (stretch_d == 0) scl_in = 1'b1;
          else begin
            hold_cnt = stretch_d;
            holding = 1'b1;
          end
        end
      end
    end
  end

  task automatic run_case(input int lo_f, input int hi_f, input int hs_f, input int top_f,
                          input int pairs, input int d, input bit midchg, input string req);
    int lo, hi, hi_st;
    logic [31:0] w;
    w = {top_f[7:0], hi_f[7:0], hs_f[7:0], lo_f[7:0]};
    @(negedge clk);
    cur_req = req;
    div_word = w;
    repeat (2) @(negedge clk);
    lo = lo_f + 3;
    hi = (hi_f == 0 ? lo_f : hi_f) + 3;
    hi_st = (d >= 0) ? hi + d + 1 : hi;
    stretch_d = d;
    push(1'b0, hi);
    for (int i = 0; i < pairs; i++) begin
      push(1'b1, lo);
      push(1'b0, hi_st);
    end
    run = 1'b1;
    if (midchg) begin
      repeat (3) @(negedge clk);
      div_word = ~w;
    end
    while (exp_kind.size() != 0) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(scl_out == 1'b1 && !scl_rise && !scl_fall, "R4", "idle after stop (scl_out)", int'(scl_out), 1);
    scl_in = 1'b1;
    holding = 1'b0;
    stretch_d = -1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_out == 1'b1 && !scl_rise && !scl_fall, "R4", "reset state scl_out", int'(scl_out), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(scl_out == 1'b1 && !scl_rise && !scl_fall, "R4", "idle after reset", int'(scl_out), 1);

    run_case(4,   0,   3,    0, 3, -1, 1'b0, "R1 R5");
    run_case(20,  10,  3,    0, 3, -1, 1'b0, "R2");
    run_case(93,  0,   3,    0, 1, -1, 1'b0, "R1");
    run_case(0,   0,   3,    0, 3, -1, 1'b0, "R1");
    run_case(255, 127, 3,    0, 1, -1, 1'b0, "R2");
    run_case(4,   0,   3,    0, 2,  5, 1'b0, "R6");
    run_case(6,   3,   3,    0, 2,  0, 1'b0, "R6");
    run_case(8,   4,   3,    0, 2, -1, 1'b1, "R7");
    run_case(8,   4, 255, 8'hA5, 2, -1, 1'b0, "R8");
    run_case(5,   0,   3,    0, 0, -1, 1'b0, "R4");

    check(exp_kind.size() == 0, "R3", "leftover expected edges", exp_kind.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog %s: actual %0d expected %0d", cur_req, exp_kind.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule